// File: doc/BRIEF.md
# Sound Register Window Decoder with Diagnostic Port

This block sits between the CPU bus and a five-channel sound generator. It watches a 32-entry register window starting at address 0x4000 and turns each qualified bus access into a strobe: one write strobe per writable register, one read strobe per readable register. The sound channels use these strobes to load their own state; the decoder holds no channel registers besides its own diagnostic ones.

Three further offsets (0x18, 0x19, 0x1A) form a concealed diagnostic port that responds only while the `testEn` input is high. Reading it returns the live 4-bit levels of the two pulse channels, the triangle and the noise channel, and the 7-bit delta-modulation level. Writing offset 0x1A preloads the triangle sequencer step (with a one-cycle load strobe) and sets or clears a channel-lock flag. While the lock is set, the pulse channels are told to ignore their zeroing sources, the noise channel to ignore its shift-register bit, and the triangle step clock is blocked inside this block.

Top module: `audio_reg_decode`

## Requirements
- R1: No strobe of either kind is produced unless `cpuSel` is high and `cpuAddr[15:5]` equals the base 0x4000 shifted right by five.
- R2: A write whose first cycle (cpuSel high, cpuRnw low, cpuSel low in the previous cycle) hits a writable offset raises exactly bit `offset` of `wrStrobe` during the following cycle only; writable offsets are 0x00 to 0x17 by default, plus 0x1A when `testEn` is high.
- R3: A read (cpuRnw high) of a readable offset raises bit `offset` of `rdStrobe` in the same cycle; readable offsets are 0x15 by default, plus 0x18, 0x19 and 0x1A when `testEn` is high.
- R4: A diagnostic read of offset 0x18 returns `pulse0Lvl` on `rdData[3:0]` and `pulse1Lvl` on `rdData[7:4]`.
- R5: A diagnostic read of offset 0x19 returns `triLvl` on `rdData[3:0]` and `noiseLvl` on `rdData[7:4]`.
- R6: A diagnostic read of offset 0x1A returns `dmcLvl` on `rdData[6:0]` with `rdData[7]` zero.
- R7: Every other cycle, including reads of any other offset and diagnostic reads with `testEn` low, drives `rdData` to zero.
- R8: With `testEn` low, accesses to 0x18 to 0x1A produce no strobe and leave `chanLock` and `triPreload` unchanged.
- R9: A diagnostic write places `cpuData[4:0]` on `triPreload` and pulses `triPreloadStb` for exactly the cycle after the access.
- R10: The same write sets `chanLock` to `cpuData[7]`, visible from the cycle after the access; it changes at no other time.
- R11: `triTickOut` equals `triTickIn` while `chanLock` is low and is held low while `chanLock` is high.
- R12: Reset (rstN low) clears `chanLock`, `triPreload`, `triPreloadStb` and `wrStrobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | CPU address |
| cpuData | input | 8 | CPU write data |
| cpuRnw | input | 1 | High for read, low for write |
| cpuSel | input | 1 | Chip-select for the sound register space |
| testEn | input | 1 | Enables the diagnostic port |
| pulse0Lvl | input | 4 | Live level of pulse channel 0 |
| pulse1Lvl | input | 4 | Live level of pulse channel 1 |
| triLvl | input | 4 | Live level of the triangle channel |
| noiseLvl | input | 4 | Live level of the noise channel |
| dmcLvl | input | 7 | Live level of the delta-modulation channel |
| triTickIn | input | 1 | Triangle step clock from the timer |
| wrStrobe | output | 32 | One-hot write strobes, one per offset |
| rdStrobe | output | 32 | Read strobes, one per offset |
| rdData | output | 8 | Diagnostic read data, zero otherwise |
| triPreload | output | 5 | Triangle sequencer step to load |
| triPreloadStb | output | 1 | One-cycle load strobe for `triPreload` |
| chanLock | output | 1 | Channel-lock flag for the channels |
| triTickOut | output | 1 | Triangle step clock after lock gating |

## Verification
The bench builds the block with its default parameters: a 16-bit address, base 0x4000, a five-bit offset field, writes allowed at 0x00 to 0x17 and a single normal readable register at 0x15. With these values every offset of the window, the diagnostic trio on both sides of `testEn`, and addresses just outside the window are all reachable by the random mix, so the gating of each strobe bit and the lock-driven clock block are exercised against both polarities.

// File: rtl/aud_dec_pkg.sv
package aud_dec_pkg;

  // Decoded diagnostic-port requests passed from control to datapath.
  typedef struct packed {
    logic diagWr;     // first cycle of a qualified write to the lock/preload offset
    logic rdPulse;    // qualified read of the pulse-level offset
    logic rdTriNoise; // qualified read of the triangle/noise offset
    logic rdDelta;    // qualified read of the delta-modulation offset
  } diagCtl_t;

endpackage

// File: rtl/aud_dec_ctrl.sv
module aud_dec_ctrl
  import aud_dec_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned OFF_W     = 5,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4000,
  parameter logic [(1<<OFF_W)-1:0] WR_MASK = 32'h00FF_FFFF,
  parameter logic [(1<<OFF_W)-1:0] RD_MASK = 32'h0020_0000,
  parameter int unsigned PULSE_OFF = 24,
  parameter int unsigned TRINS_OFF = 25,
  parameter int unsigned DELTA_OFF = 26
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      cpuAddr,
  input  logic                   cpuRnw,
  input  logic                   cpuSel,
  input  logic                   testEn,
  output logic [(1<<OFF_W)-1:0]  wrStrobe,
  output logic [(1<<OFF_W)-1:0]  rdStrobe,
  output diagCtl_t               diagCtl
);

  localparam int unsigned NREG = 1 << OFF_W;

  logic              selQ;
  logic              baseHit;
  logic              writeStart;
  logic              readNow;
  logic [OFF_W-1:0]  offset;
  logic [NREG-1:0]   wrNext;

  assign offset     = cpuAddr[OFF_W-1:0];
  assign baseHit    = cpuSel && (cpuAddr[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W]);
  assign writeStart = baseHit && !cpuRnw && !selQ;
  assign readNow    = baseHit && cpuRnw;

  always_ff @(posedge clk) begin
    if (!rstN) selQ <= 1'b0;
    else       selQ <= cpuSel;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam bit IS_DIAG_RD = (i == PULSE_OFF) || (i == TRINS_OFF) || (i == DELTA_OFF);
    localparam bit IS_DIAG_WR = (i == DELTA_OFF);
    logic hit;
    logic wrAllow;
    logic rdAllow;
    assign hit     = (offset == OFF_W'(i));
    assign wrAllow = WR_MASK[i] || (IS_DIAG_WR && testEn);
    assign rdAllow = RD_MASK[i] || (IS_DIAG_RD && testEn);
    assign wrNext[i]   = writeStart && hit && wrAllow;
    assign rdStrobe[i] = readNow && hit && rdAllow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) wrStrobe <= '0;
    else       wrStrobe <= wrNext;
  end

  always_comb begin
    diagCtl            = '0;
    diagCtl.diagWr     = writeStart && testEn && (offset == OFF_W'(DELTA_OFF));
    diagCtl.rdPulse    = readNow && testEn && (offset == OFF_W'(PULSE_OFF));
    diagCtl.rdTriNoise = readNow && testEn && (offset == OFF_W'(TRINS_OFF));
    diagCtl.rdDelta    = readNow && testEn && (offset == OFF_W'(DELTA_OFF));
  end

endmodule

// File: rtl/aud_dec_dp.sv
module aud_dec_dp
  import aud_dec_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned LVL_W   = 4,
  parameter int unsigned DELTA_W = 7,
  parameter int unsigned STEP_W  = 5,
  parameter int unsigned LOCK_BIT = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  diagCtl_t           diagCtl,
  input  logic [DATA_W-1:0]  cpuData,
  input  logic [LVL_W-1:0]   pulse0Lvl,
  input  logic [LVL_W-1:0]   pulse1Lvl,
  input  logic [LVL_W-1:0]   triLvl,
  input  logic [LVL_W-1:0]   noiseLvl,
  input  logic [DELTA_W-1:0] dmcLvl,
  input  logic               triTickIn,
  output logic [DATA_W-1:0]  rdData,
  output logic [STEP_W-1:0]  triPreload,
  output logic               triPreloadStb,
  output logic               chanLock,
  output logic               triTickOut
);

  localparam int unsigned PAIR_W = 2 * LVL_W;

  logic [PAIR_W-1:0] pulsePair;
  logic [PAIR_W-1:0] triNoisePair;

  assign pulsePair    = {pulse1Lvl, pulse0Lvl};
  assign triNoisePair = {noiseLvl, triLvl};

  always_comb begin
    rdData = '0;
    if (diagCtl.rdPulse)         rdData = DATA_W'(pulsePair);
    else if (diagCtl.rdTriNoise) rdData = DATA_W'(triNoisePair);
    else if (diagCtl.rdDelta)    rdData = DATA_W'(dmcLvl);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      triPreload    <= '0;
      triPreloadStb <= 1'b0;
      chanLock      <= 1'b0;
    end else begin
      triPreloadStb <= diagCtl.diagWr;
      if (diagCtl.diagWr) begin
        triPreload <= cpuData[STEP_W-1:0];
        chanLock   <= cpuData[LOCK_BIT];
      end
    end
  end

  assign triTickOut = triTickIn && !chanLock;

endmodule

// File: rtl/audio_reg_decode.sv
module audio_reg_decode
  import aud_dec_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned OFF_W     = 5,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4000,
  parameter logic [(1<<OFF_W)-1:0] WR_MASK = 32'h00FF_FFFF,
  parameter logic [(1<<OFF_W)-1:0] RD_MASK = 32'h0020_0000,
  parameter int unsigned LVL_W     = 4,
  parameter int unsigned DELTA_W   = 7,
  parameter int unsigned STEP_W    = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic [DATA_W-1:0]     cpuData,
  input  logic                  cpuRnw,
  input  logic                  cpuSel,
  input  logic                  testEn,
  input  logic [LVL_W-1:0]      pulse0Lvl,
  input  logic [LVL_W-1:0]      pulse1Lvl,
  input  logic [LVL_W-1:0]      triLvl,
  input  logic [LVL_W-1:0]      noiseLvl,
  input  logic [DELTA_W-1:0]    dmcLvl,
  input  logic                  triTickIn,
  output logic [(1<<OFF_W)-1:0] wrStrobe,
  output logic [(1<<OFF_W)-1:0] rdStrobe,
  output logic [DATA_W-1:0]     rdData,
  output logic [STEP_W-1:0]     triPreload,
  output logic                  triPreloadStb,
  output logic                  chanLock,
  output logic                  triTickOut
);

  diagCtl_t diagCtl;

  aud_dec_ctrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BASE_ADDR(BASE_ADDR),
    .WR_MASK(WR_MASK), .RD_MASK(RD_MASK),
    .PULSE_OFF(24), .TRINS_OFF(25), .DELTA_OFF(26)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRnw(cpuRnw),
    .cpuSel(cpuSel), .testEn(testEn),
    .wrStrobe(wrStrobe), .rdStrobe(rdStrobe), .diagCtl(diagCtl)
  );

  aud_dec_dp #(
    .DATA_W(DATA_W), .LVL_W(LVL_W), .DELTA_W(DELTA_W),
    .STEP_W(STEP_W), .LOCK_BIT(DATA_W-1)
  ) dp_i (
    .clk(clk), .rstN(rstN), .diagCtl(diagCtl), .cpuData(cpuData),
    .pulse0Lvl(pulse0Lvl), .pulse1Lvl(pulse1Lvl), .triLvl(triLvl),
    .noiseLvl(noiseLvl), .dmcLvl(dmcLvl), .triTickIn(triTickIn),
    .rdData(rdData), .triPreload(triPreload), .triPreloadStb(triPreloadStb),
    .chanLock(chanLock), .triTickOut(triTickOut)
  );

endmodule

// File: rtl/aud_dec_chk.sv
module aud_dec_chk (
  input logic        clk,
  input logic        rstN,
  input logic        testEn,
  input logic        cpuSel,
  input logic [31:0] wrStrobe,
  input logic [31:0] rdStrobe,
  input logic [7:0]  rdData,
  input logic        triPreloadStb,
  input logic        chanLock,
  input logic        triTickIn,
  input logic        triTickOut
);

  a_r2_wr_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrStrobe));

  a_r2_wr_single: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe != '0) |=> (wrStrobe == '0));

  a_r1_no_sel_no_rd: assert property (@(posedge clk) disable iff (!rstN)
    !cpuSel |-> (rdStrobe == '0));

  a_r8_diag_gated: assert property (@(posedge clk) disable iff (!rstN)
    !testEn |-> (rdStrobe[26:24] == 3'b000));

  a_r6_top_bit_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe[26] |-> (rdData[7] == 1'b0));

  a_r9_stb_matches_wr: assert property (@(posedge clk) disable iff (!rstN)
    triPreloadStb |-> wrStrobe[26]);

  a_r10_lock_stable: assert property (@(posedge clk) disable iff (!rstN)
    !triPreloadStb |-> $stable(chanLock));

  a_r11_tick_blocked: assert property (@(posedge clk) disable iff (!rstN)
    chanLock |-> !triTickOut);

  a_r11_tick_pass: assert property (@(posedge clk) disable iff (!rstN)
    (!chanLock && triTickIn) |-> triTickOut);

endmodule

bind audio_reg_decode aud_dec_chk chk_i (
  .clk(clk), .rstN(rstN), .testEn(testEn), .cpuSel(cpuSel),
  .wrStrobe(wrStrobe), .rdStrobe(rdStrobe), .rdData(rdData),
  .triPreloadStb(triPreloadStb), .chanLock(chanLock),
  .triTickIn(triTickIn), .triTickOut(triTickOut)
);

// File: tb/audio_reg_decode_tb_top.sv
`timescale 1ns/1ps
module audio_reg_decode_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic        cpuRnw = 1'b1;
  logic        cpuSel = 1'b0;
  logic        testEn = 1'b0;
  logic [3:0]  pulse0Lvl = '0, pulse1Lvl = '0, triLvl = '0, noiseLvl = '0;
  logic [6:0]  dmcLvl = '0;
  logic        triTickIn = 1'b0;
  logic [31:0] wrStrobe, rdStrobe;
  logic [7:0]  rdData;
  logic [4:0]  triPreload;
  logic        triPreloadStb, chanLock, triTickOut;

  int compared = 0;
  int mismatched = 0;
  logic       expLock = 1'b0;
  logic [4:0] expPre = '0;

  always #2.5 clk = ~clk;

  audio_reg_decode dut_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .cpuRnw(cpuRnw), .cpuSel(cpuSel), .testEn(testEn),
    .pulse0Lvl(pulse0Lvl), .pulse1Lvl(pulse1Lvl), .triLvl(triLvl),
    .noiseLvl(noiseLvl), .dmcLvl(dmcLvl), .triTickIn(triTickIn),
    .wrStrobe(wrStrobe), .rdStrobe(rdStrobe), .rdData(rdData),
    .triPreload(triPreload), .triPreloadStb(triPreloadStb),
    .chanLock(chanLock), .triTickOut(triTickOut)
  );

  function automatic bit inWin(logic [15:0] a);
    return a[15:5] == 11'h200;
  endfunction

  function automatic logic [31:0] expWr(logic [15:0] a, logic te);
    logic [4:0] o = a[4:0];
    if (!inWin(a)) return '0;
    if (o < 5'd24) return 32'd1 << o;
    if (o == 5'd26 && te) return 32'd1 << o;
    return '0;
  endfunction

  function automatic logic [31:0] expRd(logic [15:0] a, logic te);
    logic [4:0] o = a[4:0];
    if (!inWin(a)) return '0;
    if (o == 5'd21) return 32'd1 << o;
    if (o >= 5'd24 && o <= 5'd26 && te) return 32'd1 << o;
    return '0;
  endfunction

  function automatic logic [7:0] expData(logic [15:0] a, logic te);
    if (!inWin(a) || !te) return '0;
    case (a[4:0])
      5'd24: return {pulse1Lvl, pulse0Lvl};
      5'd25: return {noiseLvl, triLvl};
      5'd26: return {1'b0, dmcLvl};
      default: return '0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic randLevels();
    pulse0Lvl = 4'($urandom); pulse1Lvl = 4'($urandom);
    triLvl = 4'($urandom); noiseLvl = 4'($urandom);
    dmcLvl = 7'($urandom); triTickIn = 1'($urandom);
  endtask

  // Write access: driven one cycle, checked in the following cycle and the one after.
  task automatic doWrite(logic [15:0] a, logic [7:0] d, logic te);
    logic diag;
    @(negedge clk);
    cpuAddr = a; cpuData = d; cpuRnw = 1'b0; cpuSel = 1'b1; testEn = te;
    randLevels();
    diag = inWin(a) && a[4:0] == 5'd26 && te;
    @(negedge clk);
    cpuSel = 1'b0; cpuData = 8'($urandom);
    if (diag) begin expLock = d[7]; expPre = d[4:0]; end
    #0.5;
    check("R2 wrStrobe", wrStrobe, expWr(a, te));
    check("R9 triPreloadStb", 32'(triPreloadStb), 32'(diag));
    check("R9 triPreload", 32'(triPreload), 32'(expPre));
    check("R10 chanLock", 32'(chanLock), 32'(expLock));
    check("R11 triTickOut", 32'(triTickOut), 32'(triTickIn && !expLock));
    @(negedge clk);
    #0.5;
    check("R2 single pulse", wrStrobe, 32'd0);
    check("R9 stb single", 32'(triPreloadStb), 32'd0);
  endtask

  task automatic doRead(logic [15:0] a, logic te);
    @(negedge clk);
    cpuAddr = a; cpuRnw = 1'b1; cpuSel = 1'b1; testEn = te;
    randLevels();
    #0.5;
    check("R3 rdStrobe", rdStrobe, expRd(a, te));
    check("R4/R5/R6/R7 rdData", 32'(rdData), 32'(expData(a, te)));
    check("R11 triTickOut", 32'(triTickOut), 32'(triTickIn && !expLock));
    @(negedge clk);
    cpuSel = 1'b0;
    #0.5;
    check("R1 no sel rd", rdStrobe, 32'd0);
    check("R7 idle rdData", 32'(rdData), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd1357));
    fork
      begin
        repeat (3) @(negedge clk);
        check("R12 wrStrobe reset", wrStrobe, 32'd0);
        check("R12 lock reset", 32'(chanLock), 32'd0);
        check("R12 preload reset", 32'(triPreload), 32'd0);
        check("R12 stb reset", 32'(triPreloadStb), 32'd0);
        rstN = 1'b1;
        // Directed corners
        doRead(16'h4018, 1'b1);                // R4
        doRead(16'h4019, 1'b1);                // R5
        doRead(16'h401A, 1'b1);                // R6
        doRead(16'h4018, 1'b0);                // R8 gated read
        doRead(16'h4015, 1'b0);                // R3 normal readable
        doRead(16'h4003, 1'b1);                // R7 write-only offset
        doWrite(16'h401A, 8'h95, 1'b1);        // R9 R10 lock on
        doWrite(16'h401A, 8'h0A, 1'b0);        // R8 gated write ignored
        doRead(16'h401A, 1'b0);                // R8 read gated
        doWrite(16'h4017, 8'hFF, 1'b1);        // R2 last normal
        doWrite(16'h401B, 8'hFF, 1'b1);        // R2 non-writable
        doWrite(16'h601A, 8'h9F, 1'b1);        // R1 outside window
        doWrite(16'h401A, 8'h13, 1'b1);        // R10 lock off
        doWrite(16'h4000, 8'h00, 1'b1);        // R2 first offset
        // Random mix
        for (int n = 0; n < 400; n++) begin
          logic [15:0] a;
          logic te;
          a  = ($urandom % 4 != 0) ? (16'h4000 | 16'($urandom % 32)) : 16'($urandom);
          te = 1'($urandom);
          if ($urandom % 2) doRead(a, te);
          else doWrite(a, 8'($urandom), te);
        end
      end
      begin
        #100000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule